// File: doc/BRIEF.md
# Quarter-Rate I/Q Mixer with Channel Routing

This block takes one pair of signed in-phase (I) and quadrature (Q) samples per clock and drives two signed DAC channels, A and B. A mode select routes the samples in one of three ways. Dual-channel mode passes I to A and Q to B with no mixing. Modulator mode mixes the pair with a carrier at a quarter of the sample rate and drives the result on B only, with A held at zero. Sideband mode drives a Hilbert pair: the mixed value on A and its quadrature partner on B.

The carrier is fixed at fs/4, so the cosine is +1, 0, -1, 0 and the sine is 0, +1, 0, -1. No multiplier is used: each output is an input sample, its negation, or zero. The phase is a four-state machine with states PH0, PH1, PH2 and PH3. The *advance* transition steps PH0→PH1→PH2→PH3→PH0 once per clock. The *restart* transition applies in any cycle where the mode input differs from the mode of the previous cycle: that sample is mixed at PH0 and the machine moves on to PH1. A reverse-spectrum bit negates the sine term. An upper-sideband bit inverts channel B in sideband mode. Every negation saturates.

Top module: `qmix_top`

## Requirements
- R1: During reset both outputs are zero. Reset leaves the phase at PH0 and the stored mode at dual-channel (mode code 2'b00).
- R2: Outputs are registered. Inputs present at a rising clock edge show on `a_out`/`b_out` after that edge.
- R3: Mode 2'b00 (dual-channel): A = I and B = Q. `rev_spec` and `usb_inv` have no effect.
- R4: Mode 2'b01 (modulator): A = 0 and B = I·cos − Q·sin.
- R5: Per sample, the phase states PH0..PH3 give cos = +1, 0, −1, 0 and sin = 0, +1, 0, −1. The phase advances one state per clock.
- R6: When `rev_spec` = 1, the sine term is negated before mixing. This applies in both mixing modes.
- R7: Mode 2'b10 (sideband): A = I·cos − Q·sin and B = I·sin + Q·cos.
- R8: In sideband mode, `usb_inv` = 1 drives B with the negation of the quadrature term. In the other modes `usb_inv` has no effect.
- R9: Every negation saturates. The code −2^(DW−1) becomes 2^(DW−1)−1.
- R10: A cycle whose mode differs from the previous cycle's mode mixes its sample at PH0. The phase then continues from PH1.
- R11: Mode 2'b11 behaves exactly like dual-channel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_in | input | DW | Signed in-phase sample |
| q_in | input | DW | Signed quadrature sample |
| mode | input | 2 | 00 dual, 01 modulator, 10 sideband, 11 dual |
| rev_spec | input | 1 | Negate sine term |
| usb_inv | input | 1 | Invert channel B in sideband mode |
| a_out | output | DW | Signed channel A |
| b_out | output | DW | Signed channel B |

## Verification
The embedded properties are checked on every clock:
- channel A is silent in modulator mode;
- both dual-channel codes pass the previous samples through unchanged;
- the phase lands on PH1 after every restart;
- a sideband channel B that is inverted never shows the most negative code.

Only the bench's scenarios can show the following:
- the cycle-by-cycle carrier sequence;
- the effect of the sine negation on both mixing modes;
- saturation at full-scale inputs;
- the exact sample that a mode switch realigns.

These are compared against a behavioural model on every clock.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL = 2'b00,
        MODE_QMOD = 2'b01,
        MODE_SSB  = 2'b10,
        MODE_ALT  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } phase_e;
endpackage

// File: rtl/qmix_phase_fsm.sv
module qmix_phase_fsm
    import qmix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output phase_e     phase_o
);
    phase_e     cur_q;
    phase_e     nxt;
    logic [1:0] mode_q;
    logic       restart;

    // restart when mode differs from the mode of the previous cycle
    always_comb begin
        restart = (mode_i != mode_q);
        phase_o = restart ? PH0 : cur_q;
        unique case (phase_o)
            PH0: nxt = PH1;
            PH1: nxt = PH2;
            PH2: nxt = PH3;
            PH3: nxt = PH0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= PH0;
            mode_q <= MODE_DUAL;
        end else begin
            cur_q  <= nxt;
            mode_q <= mode_i;
        end
    end

    // R10
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cur_q == PH1));
endmodule

// File: rtl/qmix_term.sv
module qmix_term
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    input  phase_e               phase_i,
    input  logic                 rev_i,
    output logic signed [DW-1:0] mix_o,
    output logic signed [DW-1:0] hil_o
);
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    function automatic logic signed [DW-1:0] sneg(input logic signed [DW-1:0] x);
        return (x == MINV) ? ~x : -x;
    endfunction

    // mix = I*cos - Q*sin, hil = I*sin + Q*cos; rev flips the sine sign
    always_comb begin
        unique case (phase_i)
            PH0: begin
                mix_o = i_i;
                hil_o = q_i;
            end
            PH1: begin
                mix_o = rev_i ? q_i : sneg(q_i);
                hil_o = rev_i ? sneg(i_i) : i_i;
            end
            PH2: begin
                mix_o = sneg(i_i);
                hil_o = sneg(q_i);
            end
            PH3: begin
                mix_o = rev_i ? sneg(q_i) : q_i;
                hil_o = rev_i ? i_i : sneg(i_i);
            end
        endcase
    end
endmodule

// File: rtl/qmix_route.sv
module qmix_route
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic                 inv_i,
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    input  logic signed [DW-1:0] mix_i,
    input  logic signed [DW-1:0] hil_i,
    output logic signed [DW-1:0] a_o,
    output logic signed [DW-1:0] b_o
);
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] a_nxt, b_nxt;

    function automatic logic signed [DW-1:0] sneg(input logic signed [DW-1:0] x);
        return (x == MINV) ? ~x : -x;
    endfunction

    always_comb begin
        unique case (mode_i)
            MODE_QMOD: begin
                a_nxt = '0;
                b_nxt = mix_i;
            end
            MODE_SSB: begin
                a_nxt = mix_i;
                b_nxt = inv_i ? sneg(hil_i) : hil_i;
            end
            default: begin
                a_nxt = i_i;
                b_nxt = q_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o <= '0;
            b_o <= '0;
        end else begin
            a_o <= a_nxt;
            b_o <= b_nxt;
        end
    end

    // R4
    a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_QMOD) |=> (a_o == '0));

    // R3
    dual_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DUAL || mode_i == MODE_ALT) |=>
        (a_o == $past(i_i) && b_o == $past(q_i)));

    // R9
    ssb_nomin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SSB && inv_i) |=> (b_o != MINV));
endmodule

// File: rtl/qmix_top.sv
module qmix_top
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    input  logic [1:0]           mode,
    input  logic                 rev_spec,
    input  logic                 usb_inv,
    output logic signed [DW-1:0] a_out,
    output logic signed [DW-1:0] b_out
);
    phase_e               phase;
    logic signed [DW-1:0] mix, hil;

    qmix_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .phase_o (phase)
    );

    qmix_term #(.DW(DW)) u_term (
        .i_i     (i_in),
        .q_i     (q_in),
        .phase_i (phase),
        .rev_i   (rev_spec),
        .mix_o   (mix),
        .hil_o   (hil)
    );

    qmix_route #(.DW(DW)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .inv_i  (usb_inv),
        .i_i    (i_in),
        .q_i    (q_in),
        .mix_i  (mix),
        .hil_i  (hil),
        .a_o    (a_out),
        .b_o    (b_out)
    );
endmodule

// File: tb/qmix_top_tb.sv
module qmix_top_tb;
    localparam int DW = 16;
    localparam int MAXV = 32767;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] i_in = '0, q_in = '0;
    logic [1:0]           mode = 2'b00;
    logic                 rev_spec = 1'b0, usb_inv = 1'b0;
    logic signed [DW-1:0] a_out, b_out;

    int total = 0, bad = 0;
    int ph = 0, pm = 0;
    int seed = 12345;
    bit finished = 0;

    always #2.5 clk = ~clk;

    qmix_top #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .i_in(i_in), .q_in(q_in), .mode(mode),
        .rev_spec(rev_spec), .usb_inv(usb_inv), .a_out(a_out), .b_out(b_out)
    );

    function automatic int clampv(int x);
        return (x > MAXV) ? MAXV : x;
    endfunction

    function automatic int nextv();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return ((seed >>> 8) & 16'hffff) - 32768;
    endfunction

    task automatic step(int iv, int qv, int md, bit rv, bit inv, string tag);
        int c, s, m, h, ea, eb, eff;
        i_in = iv[DW-1:0]; q_in = qv[DW-1:0];
        mode = md[1:0]; rev_spec = rv; usb_inv = inv;
        eff = (md != pm) ? 0 : ph;
        c = (eff == 0) ? 1 : (eff == 2) ? -1 : 0;
        s = (eff == 1) ? 1 : (eff == 3) ? -1 : 0;
        if (rv) s = -s;
        m = clampv(iv * c - qv * s);
        h = clampv(iv * s + qv * c);
        if (md == 1) begin ea = 0; eb = m; end
        else if (md == 2) begin ea = m; eb = inv ? clampv(-h) : h; end
        else begin ea = iv; eb = qv; end
        pm = md; ph = (eff + 1) % 4;
        @(negedge clk);
        total++;
        if (int'(a_out) != ea || int'(b_out) != eb) begin
            bad++;
            $display("FAIL %s: a=%0d b=%0d expected a=%0d b=%0d", tag,
                     a_out, b_out, ea, eb);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (a_out != '0 || b_out != '0) begin
            bad++;
            $display("FAIL R1: a=%0d b=%0d expected a=0 b=0", a_out, b_out);
        end
        rst_n = 1'b1;
        // R2: first sample appears after one edge
        step(1234, -567, 0, 0, 0, "R2");
        for (int k = 0; k < 8; k++) step(nextv(), nextv(), 0, k[0], k[1], "R3");
        for (int k = 0; k < 6; k++) step(nextv(), nextv(), 3, k[0], 1, "R11");
        // R5 / R4: carrier walk in modulator mode
        for (int k = 0; k < 8; k++) step(100 + k, 200 + k, 1, 0, 0, "R5");
        for (int k = 0; k < 8; k++) step(nextv(), nextv(), 1, 0, k[0], "R4");
        for (int k = 0; k < 8; k++) step(nextv(), nextv(), 1, 1, 0, "R6");
        for (int k = 0; k < 8; k++) step(nextv(), nextv(), 2, 0, 0, "R7");
        for (int k = 0; k < 8; k++) step(nextv(), nextv(), 2, k[2], 1, "R8");
        for (int k = 0; k < 8; k++) step(nextv(), nextv(), 2, 1, 0, "R6");
        // R9: full-scale negative codes in every phase
        for (int k = 0; k < 8; k++) step(-32768, -32768, 2, k[2], k[0], "R9");
        for (int k = 0; k < 8; k++) step(-32768, 32767, 1, k[2], 0, "R9");
        // R10: mode switches at odd phases
        step(300, 400, 2, 0, 0, "R10");
        step(301, 401, 1, 0, 0, "R10");
        step(302, 402, 1, 0, 0, "R10");
        step(303, 403, 1, 0, 0, "R10");
        step(304, 404, 2, 0, 0, "R10");
        step(305, 405, 0, 0, 0, "R10");
        step(306, 406, 2, 0, 0, "R10");
        step(307, 407, 2, 0, 0, "R10");
        for (int k = 0; k < 200; k++)
            step(nextv(), nextv(), (k / 7) % 4, k[3], k[4], "R10");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule